// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block watches the digital comparator flags of a single-phase buck regulator controller. It turns them into latched faults and into gate-control masks. The flags it watches are undervoltage, overvoltage, overcurrent, short-circuit, and a pair of severe-overvoltage threshold flags (an upper crossing and a lower crossing). Each ordinary fault must hold for its own qualification time before it latches. The qualification time is counted in clock cycles and derived from a clock frequency and a duration in nanoseconds. A latched ordinary fault pulls power-good low and forces both gates off. It holds until the enable input drops.

Severe overvoltage needs no qualification. One clock after the upper flag is seen, the high-side gate is masked and power-good is dropped. The low-side gate then follows a hysteresis loop: it is forced on at the upper crossing and released at the lower crossing. This loop keeps running until the supply-good input goes low. The supply-good input is the only reset of the block. It is asynchronous and active low, and it takes priority over everything.

Top module: `vreg_fault_supervisor`

## Requirements
- R1: An undervoltage flag held high for UV_TICKS consecutive clock edges latches fault_code bit 0. Fewer edges latch nothing. A single low cycle restarts the count.
- R2: An overvoltage flag held high for OV_TICKS consecutive edges latches fault_code bit 1. Fewer edges latch nothing.
- R3: An overcurrent flag latches fault_code bit 2 after OC_TICKS consecutive edges. A short-circuit flag latches bit 3 after SC_TICKS consecutive edges. Fewer edges latch nothing.
- R4: While an ordinary fault (bits 3:0) is latched and no severe overvoltage is latched, the outputs are pgood=0, hs_mask=1, ls_mask_lo=1 and ls_force_hi=0.
- R5: An ordinary fault stays latched while en is high, even after its flag returns low. The first edge with en low clears bits 3:0. pgood is 0 while en is low and returns to 1 once en is high again with no fault latched.
- R6: Bits 3:0 hold a one-hot record of the first ordinary fault only; later faults do not change it. When faults qualify in the same cycle, the order of precedence is short-circuit, then overcurrent, then overvoltage, then undervoltage.
- R7: One edge with sovp_hi high sets fault_code bit 4. From the next cycle on it gives hs_mask=1, pgood=0 and ls_force_hi=1, with no qualification delay.
- R8: After a severe overvoltage, an edge with sovp_lo high (and sovp_hi low) gives ls_force_hi=0 and ls_mask_lo=1. A later edge with sovp_hi high forces the low side on again. ls_force_hi and ls_mask_lo are never both 1.
- R9: Severe overvoltage is not cleared by en going low. Bit 4, hs_mask=1 and pgood=0 persist until supply_ok goes low.
- R10: Severe overvoltage still engages when an ordinary fault is already latched. It then overrides that fault's low-side action, while bits 3:0 keep their value.
- R11: supply_ok low clears all latches and timers at once. The outputs are then fault_code=0, hs_mask=0, ls_force_hi=0, ls_mask_lo=0 and pgood equal to en, and the flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock for qualification counters |
| supply_ok | input | 1 | Supply-good; low is an asynchronous reset of all state |
| en | input | 1 | Regulator enable; low clears ordinary faults |
| uv_flag | input | 1 | Output more than the undervoltage margin below the soft-start reference |
| ov_flag | input | 1 | Output more than the overvoltage margin above the soft-start reference |
| oc_flag | input | 1 | Overcurrent comparator |
| sc_flag | input | 1 | Short-circuit comparator |
| sovp_hi | input | 1 | Output above the severe-overvoltage upper threshold |
| sovp_lo | input | 1 | Output below the severe-overvoltage release threshold |
| pgood | output | 1 | Power-good, high when enabled and fault free |
| hs_mask | output | 1 | Force the high-side gate low |
| ls_force_hi | output | 1 | Force the low-side gate high |
| ls_mask_lo | output | 1 | Force the low-side gate low |
| fault_code | output | 5 | {severe OV, SC, OC, OV, UV} latched fault record |

## Verification
Each ordinary flag is held for exactly its qualification count, and also for one edge less. This separates a correct threshold from an off-by-one. A flag with a one-cycle gap is used to show whether the timer restarts or merely pauses. Staggered overvoltage and undervoltage flags that qualify on the same edge test the order of precedence, and a fault arriving after another tests that the first-fault record holds. Severe-overvoltage pulses applied alone, after an ordinary fault, across an enable drop, and against the lower crossing show whether the hysteresis loop, the override and the supply-only clear are each kept separate.

// File: rtl/vfs_pkg.sv
`timescale 1ns/1ps
package vfs_pkg;
  localparam int NUM_STD = 4;
  localparam int CODE_W  = NUM_STD + 1;

  typedef enum int {
    IDX_UV   = 0,
    IDX_OV   = 1,
    IDX_OC   = 2,
    IDX_SC   = 3,
    IDX_SOVP = 4
  } fault_idx_e;

  // Cycles of a clock at clk_hz that span dur_ns, never below one.
  function automatic int ns_to_ticks(int clk_hz, int dur_ns);
    longint t;
    t = (longint'(clk_hz) * longint'(dur_ns)) / 64'd1_000_000_000;
    if (t < 1) t = 1;
    return int'(t);
  endfunction

  // One-hot pick of the highest-index request (SC > OC > OV > UV).
  function automatic logic [NUM_STD-1:0] first_pick(logic [NUM_STD-1:0] req);
    logic [NUM_STD-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_STD; i++) begin
      if (req[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/vfs_qualifier.sv
`timescale 1ns/1ps
module vfs_qualifier #(
  parameter int TICKS = 1
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic en,
  input  logic flag,
  output logic qual
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  // Saturating run-length counter; any low cycle restarts it.
  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)          cnt <= '0;
    else if (!en || !flag)   cnt <= '0;
    else if (cnt != LAST)    cnt <= cnt + CW'(1);
  end

  assign qual = en & flag & (cnt == LAST);
endmodule

// File: rtl/vfs_std_latch.sv
`timescale 1ns/1ps
module vfs_std_latch
  import vfs_pkg::*;
(
  input  logic               clk,
  input  logic               supply_ok,
  input  logic               en,
  input  logic [NUM_STD-1:0] qual_vec,
  output logic [NUM_STD-1:0] std_code,
  output logic               std_latched
);
  logic [NUM_STD-1:0] code_q;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)                        code_q <= '0;
    else if (!en)                          code_q <= '0;
    else if (code_q == '0 && |qual_vec)    code_q <= first_pick(qual_vec);
  end

  assign std_code    = code_q;
  assign std_latched = |code_q;
endmodule

// File: rtl/vfs_sovp_ctrl.sv
`timescale 1ns/1ps
module vfs_sovp_ctrl (
  input  logic clk,
  input  logic supply_ok,
  input  logic sovp_hi,
  input  logic sovp_lo,
  output logic sovp_latched,
  output logic ls_on
);
  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      sovp_latched <= 1'b0;
      ls_on        <= 1'b0;
    end else begin
      if (sovp_hi) sovp_latched <= 1'b1;
      // Hysteresis: upper crossing wins if both were ever seen together.
      if (sovp_hi)      ls_on <= 1'b1;
      else if (sovp_lo) ls_on <= 1'b0;
    end
  end
endmodule

// File: rtl/vreg_fault_supervisor.sv
`timescale 1ns/1ps
module vreg_fault_supervisor
  import vfs_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int UV_NS  = 1_000_000,
  parameter int OV_NS  = 1_000_000,
  parameter int OC_NS  = 120_000,
  parameter int SC_NS  = 2_000
) (
  input  logic              clk,
  input  logic              supply_ok,
  input  logic              en,
  input  logic              uv_flag,
  input  logic              ov_flag,
  input  logic              oc_flag,
  input  logic              sc_flag,
  input  logic              sovp_hi,
  input  logic              sovp_lo,
  output logic              pgood,
  output logic              hs_mask,
  output logic              ls_force_hi,
  output logic              ls_mask_lo,
  output logic [CODE_W-1:0] fault_code
);
  localparam int UV_TICKS = ns_to_ticks(CLK_HZ, UV_NS);
  localparam int OV_TICKS = ns_to_ticks(CLK_HZ, OV_NS);
  localparam int OC_TICKS = ns_to_ticks(CLK_HZ, OC_NS);
  localparam int SC_TICKS = ns_to_ticks(CLK_HZ, SC_NS);
  localparam int TICK_TAB [NUM_STD] = '{UV_TICKS, OV_TICKS, OC_TICKS, SC_TICKS};

  // Named internal events, brought out for the checker.
  logic [NUM_STD-1:0] flag_vec;
  logic [NUM_STD-1:0] qual_vec;
  logic [NUM_STD-1:0] std_code;
  logic               std_latched;
  logic               sovp_latched;
  logic               ls_on;

  assign flag_vec = {sc_flag, oc_flag, ov_flag, uv_flag};

  for (genvar g = 0; g < NUM_STD; g++) begin : g_qual
    vfs_qualifier #(.TICKS(TICK_TAB[g])) u_q (
      .clk      (clk),
      .supply_ok(supply_ok),
      .en       (en),
      .flag     (flag_vec[g]),
      .qual     (qual_vec[g])
    );
  end

  vfs_std_latch u_std (
    .clk        (clk),
    .supply_ok  (supply_ok),
    .en         (en),
    .qual_vec   (qual_vec),
    .std_code   (std_code),
    .std_latched(std_latched)
  );

  vfs_sovp_ctrl u_sovp (
    .clk         (clk),
    .supply_ok   (supply_ok),
    .sovp_hi     (sovp_hi),
    .sovp_lo     (sovp_lo),
    .sovp_latched(sovp_latched),
    .ls_on       (ls_on)
  );

  assign pgood       = en & ~std_latched & ~sovp_latched;
  assign hs_mask     = std_latched | sovp_latched;
  assign ls_force_hi = sovp_latched & ls_on;
  assign ls_mask_lo  = sovp_latched ? ~ls_on : std_latched;
  assign fault_code  = {sovp_latched, std_code};
endmodule

// File: rtl/vfs_checker.sv
`timescale 1ns/1ps
module vfs_checker (
  input logic       clk,
  input logic       supply_ok,
  input logic       en,
  input logic       sovp_hi,
  input logic       sovp_lo,
  input logic       pgood,
  input logic       hs_mask,
  input logic       ls_force_hi,
  input logic       ls_mask_lo,
  input logic [4:0] fault_code,
  input logic [3:0] qual_vec
);
  assert_qualify_latches_R1: assert property (@(posedge clk) disable iff (!supply_ok)
    (|qual_vec) |=> (fault_code[3:0] != 4'd0));

  assert_std_gates_off_R4: assert property (@(posedge clk) disable iff (!supply_ok)
    (fault_code[3:0] != 4'd0 && !fault_code[4]) |-> (!pgood && hs_mask && ls_mask_lo && !ls_force_hi));

  assert_en_clears_std_R5: assert property (@(posedge clk) disable iff (!supply_ok)
    !en |=> (fault_code[3:0] == 4'd0));

  assert_code_onehot_R6: assert property (@(posedge clk) disable iff (!supply_ok)
    $onehot0(fault_code[3:0]));

  assert_first_fault_kept_R6: assert property (@(posedge clk) disable iff (!supply_ok)
    (fault_code[3:0] != 4'd0 && en) |=> (fault_code[3:0] == $past(fault_code[3:0])));

  assert_sovp_engage_R7: assert property (@(posedge clk) disable iff (!supply_ok)
    sovp_hi |=> (fault_code[4] && hs_mask && ls_force_hi && !pgood));

  assert_ls_exclusive_R8: assert property (@(posedge clk) disable iff (!supply_ok)
    !(ls_force_hi && ls_mask_lo));

  assert_ls_release_R8: assert property (@(posedge clk) disable iff (!supply_ok)
    (fault_code[4] && sovp_lo && !sovp_hi) |=> (ls_mask_lo && !ls_force_hi));

  assert_sovp_sticky_R9: assert property (@(posedge clk) disable iff (!supply_ok)
    fault_code[4] |=> (fault_code[4] && hs_mask && !pgood));

  assert_sovp_override_R10: assert property (@(posedge clk) disable iff (!supply_ok)
    fault_code[4] |-> (ls_force_hi != ls_mask_lo));
endmodule

bind vreg_fault_supervisor vfs_checker u_vfs_checker (
  .clk        (clk),
  .supply_ok  (supply_ok),
  .en         (en),
  .sovp_hi    (sovp_hi),
  .sovp_lo    (sovp_lo),
  .pgood      (pgood),
  .hs_mask    (hs_mask),
  .ls_force_hi(ls_force_hi),
  .ls_mask_lo (ls_mask_lo),
  .fault_code (fault_code),
  .qual_vec   (qual_vec)
);

// File: tb/test_vreg_fault_supervisor.sv
`timescale 1ns/1ps
module test_vreg_fault_supervisor;
  localparam int PERIOD_NS = 20;
  localparam int UV_NS = 400;
  localparam int OV_NS = 480;
  localparam int OC_NS = 160;
  localparam int SC_NS = 40;
  // Expected qualification counts, restated from the durations.
  localparam int T_UV = UV_NS / PERIOD_NS;
  localparam int T_OV = OV_NS / PERIOD_NS;
  localparam int T_OC = OC_NS / PERIOD_NS;
  localparam int T_SC = SC_NS / PERIOD_NS;

  typedef struct packed {
    logic [1:0] which;   // 0 UV, 1 OV, 2 OC, 3 SC
    int         delta;   // hold = ticks + delta
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, -1}, '{2'd0, 0},
    '{2'd1, -1}, '{2'd1, 0},
    '{2'd2, -1}, '{2'd2, 0},
    '{2'd3, -1}, '{2'd3, 0}
  };

  logic clk = 1'b0;
  logic supply_ok, en, uv_flag, ov_flag, oc_flag, sc_flag, sovp_hi, sovp_lo;
  logic pgood, hs_mask, ls_force_hi, ls_mask_lo;
  logic [4:0] fault_code;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD_NS/2) clk = ~clk;

  vreg_fault_supervisor #(
    .CLK_HZ(1_000_000_000 / PERIOD_NS), .UV_NS(UV_NS), .OV_NS(OV_NS),
    .OC_NS(OC_NS), .SC_NS(SC_NS)
  ) i_vreg_fault_supervisor (
    .clk(clk), .supply_ok(supply_ok), .en(en), .uv_flag(uv_flag),
    .ov_flag(ov_flag), .oc_flag(oc_flag), .sc_flag(sc_flag),
    .sovp_hi(sovp_hi), .sovp_lo(sovp_lo), .pgood(pgood), .hs_mask(hs_mask),
    .ls_force_hi(ls_force_hi), .ls_mask_lo(ls_mask_lo), .fault_code(fault_code)
  );

  function automatic int ticks_of(int w);
    case (w)
      0: return T_UV;
      1: return T_OV;
      2: return T_OC;
      default: return T_SC;
    endcase
  endfunction

  function automatic string req_of(int w);
    case (w)
      0: return "R1";
      1: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_flag(int w, logic v);
    case (w)
      0: uv_flag = v;
      1: ov_flag = v;
      2: oc_flag = v;
      default: sc_flag = v;
    endcase
  endtask

  task automatic clear_en();
    @(negedge clk) en = 1'b0;
    @(negedge clk) en = 1'b1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic supply_reset();
    @(negedge clk) supply_ok = 1'b0;
    #1;
    chk("R11", "code in reset", 32'(fault_code), 32'd0);
    chk("R11", "gates in reset", {29'd0, hs_mask, ls_force_hi, ls_mask_lo}, 32'd0);
    @(negedge clk) supply_ok = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    supply_ok = 1'b0; en = 1'b1;
    uv_flag = 1'b0; ov_flag = 1'b0; oc_flag = 1'b0; sc_flag = 1'b0;
    sovp_hi = 1'b0; sovp_lo = 1'b0;

    // Reset state, flags ignored while supply is low (R11)
    @(negedge clk);
    sovp_hi = 1'b1; sc_flag = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "code while supply low", 32'(fault_code), 32'd0);
    chk("R11", "masks while supply low", {29'd0, hs_mask, ls_force_hi, ls_mask_lo}, 32'd0);
    chk("R11", "pgood follows en", 32'(pgood), 32'd1);
    sovp_hi = 1'b0; sc_flag = 1'b0;
    @(negedge clk) supply_ok = 1'b1;

    // Vector table: each flag at its count and one edge short
    for (int i = 0; i < 8; i++) begin
      int w;
      int hold;
      logic exp;
      w    = int'(VECS[i].which);
      hold = ticks_of(w) + VECS[i].delta;
      exp  = (VECS[i].delta >= 0);
      clear_en();
      set_flag(w, 1'b1);
      repeat (hold) @(posedge clk);
      @(negedge clk) set_flag(w, 1'b0);
      chk(req_of(w), "latched code", 32'(fault_code), exp ? (32'd1 << w) : 32'd0);
      chk("R4", "high-side mask", 32'(hs_mask), 32'(exp));
      chk("R4", "low-side mask", {30'd0, ls_mask_lo, ls_force_hi}, exp ? 32'd2 : 32'd0);
      chk("R4", "pgood", 32'(pgood), 32'(!exp));
    end

    // R1: a one-cycle gap restarts the undervoltage timer
    clear_en();
    uv_flag = 1'b1;
    repeat (T_UV - 1) @(posedge clk);
    @(negedge clk) uv_flag = 1'b0;
    @(negedge clk) uv_flag = 1'b1;
    repeat (T_UV - 1) @(posedge clk);
    @(negedge clk) uv_flag = 1'b0;
    chk("R1", "gap restarts timer", 32'(fault_code), 32'd0);

    // R6: OV and UV qualify on the same edge; OV takes precedence
    clear_en();
    ov_flag = 1'b1;
    repeat (T_OV - T_UV) @(posedge clk);
    @(negedge clk) uv_flag = 1'b1;
    repeat (T_UV) @(posedge clk);
    @(negedge clk) begin uv_flag = 1'b0; ov_flag = 1'b0; end
    chk("R6", "same-cycle precedence", 32'(fault_code), 32'd2);

    // R6: a later fault leaves the first record; R5 hold and clear
    clear_en();
    sc_flag = 1'b1;
    repeat (T_SC) @(posedge clk);
    @(negedge clk) oc_flag = 1'b1;
    repeat (T_OC) @(posedge clk);
    @(negedge clk) begin oc_flag = 1'b0; sc_flag = 1'b0; end
    chk("R6", "first fault kept", 32'(fault_code), 32'd8);
    repeat (5) @(negedge clk);
    chk("R5", "held without flag", 32'(fault_code), 32'd8);
    en = 1'b0;
    @(negedge clk);
    chk("R5", "en low clears", 32'(fault_code), 32'd0);
    chk("R5", "pgood low while disabled", 32'(pgood), 32'd0);
    en = 1'b1;
    @(negedge clk);
    chk("R5", "pgood back", 32'(pgood), 32'd1);

    // R7, R8, R9: severe overvoltage alone
    pulse(sovp_hi);
    chk("R7", "sovp code", 32'(fault_code), 32'h10);
    chk("R7", "sovp gates", {28'd0, pgood, hs_mask, ls_force_hi, ls_mask_lo}, 32'b0110);
    pulse(sovp_lo);
    chk("R8", "release at low crossing", {30'd0, ls_force_hi, ls_mask_lo}, 32'b01);
    pulse(sovp_hi);
    chk("R8", "re-force at high crossing", {30'd0, ls_force_hi, ls_mask_lo}, 32'b10);
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "en low keeps sovp", {28'd0, fault_code[4], hs_mask, pgood, ls_force_hi}, 32'b1101);
    en = 1'b1;
    supply_reset();
    chk("R11", "pgood after supply reset", 32'(pgood), 32'd1);

    // R10: severe overvoltage after an ordinary fault
    clear_en();
    uv_flag = 1'b1;
    repeat (T_UV) @(posedge clk);
    @(negedge clk) uv_flag = 1'b0;
    chk("R10", "ordinary fault first", 32'(fault_code), 32'd1);
    pulse(sovp_hi);
    chk("R10", "sovp added to code", 32'(fault_code), 32'h11);
    chk("R10", "low side forced on", {29'd0, hs_mask, ls_force_hi, ls_mask_lo}, 32'b110);
    pulse(sovp_lo);
    chk("R10", "low side released", {29'd0, hs_mask, ls_force_hi, ls_mask_lo}, 32'b101);
    supply_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule